// File: doc/BRIEF.md
# Timed Sync Pulse Generator

This block produces a synchronization pulse at absolute points of a 64-bit system time that reaches it as an input and advances by a fixed step on every core clock. Software loads a start time, a cycle time and a pulse length, then raises an activation bit. The unit waits until system time reaches the start time and fires. When the cycle time is non-zero it fires again every cycle time after that. When the cycle time is zero it fires once and then stops.

No mode field exists. The operating mode comes from two zero tests taken when the unit is armed. A non-zero pulse length gives a pulse of that many clock steps. A zero pulse length gives a level that stays high until an acknowledge strobe clears it, which suits interrupt use.

The start time can be loaded in full or through its low half only. In the second case the upper half is taken from the current system time and moved one step forward if that would place the start in the past. A start-time write can also arm the unit on its own. Arming with a start time that has already passed raises an error flag and produces no pulse.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, `sync0` and `start_err` are both low.
- R2: Cyclic mode (pulse length > 0, cycle time > 0): each pulse stays high for exactly `cfg_len` clocks. Successive rising edges are cycle time apart, because each next due time equals the previous due time plus the cycle time.
- R3: Single shot mode (pulse length > 0, cycle time = 0): exactly one pulse of `cfg_len` clocks. After it the unit stays idle and silent until it is armed again.
- R4: Cyclic acknowledge mode (pulse length = 0, cycle time > 0): `sync0` stays high, even across later due times, until `sync_ack` is seen. It goes low on the clock that samples the acknowledge and rises again at a later due time.
- R5: Single shot acknowledge mode (both zero): `sync0` stays high until acknowledged and then stays low until the unit is armed again.
- R6: The first rising edge of `sync0` follows the first clock edge at which the sampled `sys_time` is greater than or equal to the start time, and it never comes earlier.
- R7: A low-half start write (`start_lo_wr`, data in `cfg_start[31:0]`) forms {upper half of `sys_time`, data}. If that value is less than `sys_time`, the upper half is incremented by one. A full write (`start_wr`) loads all 64 bits, and takes priority when both are asserted.
- R8: With `cfg_auto_act` high and `cfg_act_en` high, a start-time write re-arms the unit against the new start time on the following clock.
- R9: Arming happens on the rising edge of `cfg_act_en`, or as in R8. If the start time at arming is below `sys_time`, `start_err` goes high, the unit stays idle and no pulse follows. `start_err` clears on the next successful arming or when `cfg_act_en` falls.
- R10: `cfg_act_en` low forces `sync0` low and the unit idle, one clock later.
- R11: In cyclic fixed-width mode, a due time reached while the pulse is still high restarts the width count and keeps `sync0` high.
- R12: Mode, pulse length and cycle time are captured at arming. Changes to `cfg_len` or `cfg_cycle` while running do not affect pulse width or spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one system time step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Current system time in ns |
| cfg_start | input | 64 | Start time write data |
| start_wr | input | 1 | Load all 64 bits of start time |
| start_lo_wr | input | 1 | Load low 32 bits with upper-half extension |
| cfg_cycle | input | 32 | Cycle time in ns, zero selects single shot |
| cfg_len | input | 16 | Pulse width in clocks, zero selects acknowledge mode |
| cfg_act_en | input | 1 | Activation and output enable |
| cfg_auto_act | input | 1 | Start-time write re-arms the unit |
| sync_ack | input | 1 | Acknowledge clearing a held pulse |
| sync0 | output | 1 | Sync pulse output |
| start_err | output | 1 | Start time was already past at arming |

## Verification
The bench builds the block with its default widths: 64-bit time, 32-bit cycle and 16-bit length. Its system time starts a few hundred nanoseconds below a rollover of the low 32 bits, so a low-half start write lands just past that rollover and needs the upper-half increment. Cycle times of a few tens of nanoseconds against pulse lengths of many clocks cover the retrigger case. A cycle time shorter than the wait for an acknowledge covers the merging of missed due times while the output is held.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        MD_CYCLIC   = 2'd0,
        MD_ONESHOT  = 2'd1,
        MD_CYC_ACK  = 2'd2,
        MD_ONE_ACK  = 2'd3
    } sp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } sp_state_e;

endpackage

// File: rtl/sp_mode_decode.sv
module sp_mode_decode
    import sp_pkg::*;
#(
    parameter int CYC_W = 32,
    parameter int LEN_W = 16
) (
    input  logic [CYC_W-1:0] cycle_time,
    input  logic [LEN_W-1:0] pulse_len,
    output sp_mode_e         mode
);

    logic has_period;
    logic has_width;

    always_comb begin
        has_period = |cycle_time;
        has_width  = |pulse_len;
        unique case ({has_width, has_period})
            2'b11:   mode = MD_CYCLIC;
            2'b10:   mode = MD_ONESHOT;
            2'b01:   mode = MD_CYC_ACK;
            default: mode = MD_ONE_ACK;
        endcase
    end

endmodule

// File: rtl/sp_start_reg.sv
module sp_start_reg #(
    parameter int TIME_W = 64,
    parameter bit LO_EXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [TIME_W-1:0] wr_data,
    input  logic              wr_full,
    input  logic              wr_low,
    output logic [TIME_W-1:0] start_time,
    output logic              loaded
);

    localparam int HALF_W = TIME_W / 2;

    typedef struct packed {
        logic [TIME_W-1:0] start;
        logic              loaded;
    } reg_s;

    reg_s r_d, r_q;
    logic [TIME_W-1:0] low_value;

    generate
        if (LO_EXT) begin : g_ext
            logic [TIME_W-1:0] cand;
            logic [HALF_W-1:0] hi_bump;
            always_comb begin
                cand    = {sys_time[TIME_W-1:HALF_W], wr_data[HALF_W-1:0]};
                hi_bump = sys_time[TIME_W-1:HALF_W] + 1'b1;
                if (cand < sys_time) begin
                    low_value = {hi_bump, wr_data[HALF_W-1:0]};
                end else begin
                    low_value = cand;
                end
            end
        end else begin : g_plain
            always_comb begin
                low_value = {r_q.start[TIME_W-1:HALF_W], wr_data[HALF_W-1:0]};
            end
        end
    endgenerate

    always_comb begin
        r_d        = r_q;
        r_d.loaded = wr_full | wr_low;
        if (wr_full) begin
            r_d.start = wr_data;
        end else if (wr_low) begin
            r_d.start = low_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_time = r_q.start;
    assign loaded     = r_q.loaded;

endmodule

// File: rtl/sp_sync_fsm.sv
module sp_sync_fsm
    import sp_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int CYC_W  = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [TIME_W-1:0] start_time,
    input  logic              start_loaded,
    input  logic [CYC_W-1:0]  cfg_cycle,
    input  logic [LEN_W-1:0]  cfg_len,
    input  sp_mode_e          mode_in,
    input  logic              act_en,
    input  logic              auto_act,
    input  logic              ack,
    output logic              sync_out,
    output logic              start_err,
    output logic              arm_o,
    output logic              ack_mode_o,
    output logic              idle_o,
    output logic              wait_o
);

    localparam int               PAD_W   = TIME_W - CYC_W;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        sp_state_e         st;
        sp_mode_e          mode;
        logic [TIME_W-1:0] due;
        logic [CYC_W-1:0]  per;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  left;
        logic              out;
        logic              err;
        logic              act;
    } fsm_s;

    fsm_s r_d, r_q;
    logic arm;
    logic hit;
    logic cyc;
    logic ack_md;
    logic [TIME_W-1:0] due_next;

    always_comb begin
        arm      = act_en & (~r_q.act | (auto_act & start_loaded));
        hit      = sys_time >= r_q.due;
        cyc      = (r_q.mode == MD_CYCLIC) || (r_q.mode == MD_CYC_ACK);
        ack_md   = (r_q.mode == MD_CYC_ACK) || (r_q.mode == MD_ONE_ACK);
        due_next = r_q.due + {{PAD_W{1'b0}}, r_q.per};

        r_d     = r_q;
        r_d.act = act_en;

        if (!act_en) begin
            r_d.st  = ST_IDLE;
            r_d.out = 1'b0;
            r_d.err = 1'b0;
        end else if (arm) begin
            r_d.out = 1'b0;
            if (start_time < sys_time) begin
                r_d.st  = ST_IDLE;
                r_d.err = 1'b1;
            end else begin
                r_d.st   = ST_WAIT;
                r_d.err  = 1'b0;
                r_d.due  = start_time;
                r_d.mode = mode_in;
                r_d.per  = cfg_cycle;
                r_d.len  = cfg_len;
            end
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    if (hit) begin
                        r_d.out  = 1'b1;
                        r_d.left = r_q.len;
                        if (cyc) begin
                            r_d.due = due_next;
                        end
                        r_d.st = ack_md ? ST_HOLD : ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (cyc && hit) begin
                        r_d.left = r_q.len;
                        r_d.due  = due_next;
                    end else if (r_q.left == LEN_ONE) begin
                        r_d.out = 1'b0;
                        r_d.st  = cyc ? ST_WAIT : ST_IDLE;
                    end else begin
                        r_d.left = r_q.left - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cyc && hit) begin
                        r_d.due = due_next;
                    end
                    if (ack) begin
                        r_d.out = 1'b0;
                        r_d.st  = cyc ? ST_WAIT : ST_IDLE;
                    end
                end
                default: begin
                    r_d.out = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_out   = r_q.out;
    assign start_err  = r_q.err;
    assign arm_o      = arm;
    assign ack_mode_o = ack_md;
    assign idle_o     = (r_q.st == ST_IDLE);
    assign wait_o     = (r_q.st == ST_WAIT);

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sp_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int CYC_W  = 32,
    parameter int LEN_W  = 16,
    parameter bit LO_EXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [TIME_W-1:0] cfg_start,
    input  logic              start_wr,
    input  logic              start_lo_wr,
    input  logic [CYC_W-1:0]  cfg_cycle,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_act_en,
    input  logic              cfg_auto_act,
    input  logic              sync_ack,
    output logic              sync0,
    output logic              start_err
);

    sp_mode_e          mode;
    logic [TIME_W-1:0] start_time;
    logic              start_loaded;
    logic              arm;
    logic              ack_mode;
    logic              fsm_idle;
    logic              fsm_wait;

    sp_mode_decode #(
        .CYC_W (CYC_W),
        .LEN_W (LEN_W)
    ) u_mode (
        .cycle_time (cfg_cycle),
        .pulse_len  (cfg_len),
        .mode       (mode)
    );

    sp_start_reg #(
        .TIME_W (TIME_W),
        .LO_EXT (LO_EXT)
    ) u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_time   (sys_time),
        .wr_data    (cfg_start),
        .wr_full    (start_wr),
        .wr_low     (start_lo_wr),
        .start_time (start_time),
        .loaded     (start_loaded)
    );

    sp_sync_fsm #(
        .TIME_W (TIME_W),
        .CYC_W  (CYC_W),
        .LEN_W  (LEN_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_time     (sys_time),
        .start_time   (start_time),
        .start_loaded (start_loaded),
        .cfg_cycle    (cfg_cycle),
        .cfg_len      (cfg_len),
        .mode_in      (mode),
        .act_en       (cfg_act_en),
        .auto_act     (cfg_auto_act),
        .ack          (sync_ack),
        .sync_out     (sync0),
        .start_err    (start_err),
        .arm_o        (arm),
        .ack_mode_o   (ack_mode),
        .idle_o       (fsm_idle),
        .wait_o       (fsm_wait)
    );

endmodule

// File: rtl/sp_checker.sv
module sp_checker (
    input logic clk,
    input logic rst_n,
    input logic act_en,
    input logic sync_ack,
    input logic sync0,
    input logic start_err,
    input logic arm,
    input logic ack_mode,
    input logic idle,
    input logic waiting
);

    // R10: deactivation silences the output on the next clock
    a_r10_act_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> !sync0);

    // R9: a rejected start time never coexists with a pulse
    a_r9_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> !sync0);

    // R4 and R5: a held pulse survives until acknowledged
    a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sync0 && ack_mode && !sync_ack && act_en && !arm) |=> sync0);

    // R3: an idle unit stays silent until armed
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !arm) |=> !sync0);

    // R6: every rising edge is launched from the waiting state
    a_r6_rise_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync0) |-> $past(waiting));

endmodule

bind sync_pulse_gen sp_checker u_sp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_en    (cfg_act_en),
    .sync_ack  (sync_ack),
    .sync0     (sync0),
    .start_err (start_err),
    .arm       (arm),
    .ack_mode  (ack_mode),
    .idle      (fsm_idle),
    .waiting   (fsm_wait)
);

// File: tb/tb_sync_pulse_gen.sv
`timescale 1ns/100ps
module tb_sync_pulse_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] st = 64'h0000_0001_FFFF_FF00;
    logic [63:0] cfg_start = '0;
    logic        start_wr = 1'b0;
    logic        start_lo_wr = 1'b0;
    logic [31:0] cfg_cycle = '0;
    logic [15:0] cfg_len = '0;
    logic        cfg_act_en = 1'b0;
    logic        cfg_auto_act = 1'b0;
    logic        sync_ack = 1'b0;
    logic        sync0;
    logic        start_err;

    int n_chk = 0;
    int n_err = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sync_pulse_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_time     (st),
        .cfg_start    (cfg_start),
        .start_wr     (start_wr),
        .start_lo_wr  (start_lo_wr),
        .cfg_cycle    (cfg_cycle),
        .cfg_len      (cfg_len),
        .cfg_act_en   (cfg_act_en),
        .cfg_auto_act (cfg_auto_act),
        .sync_ack     (sync_ack),
        .sync0        (sync0),
        .start_err    (start_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_run, m_out, m_err, m_prev_act, m_prev_wr;
    logic [63:0] m_next, m_start;
    logic [31:0] m_per;
    int          m_len, m_left;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_out = 0; m_err = 0; m_prev_act = 0; m_prev_wr = 0;
            m_next = '0; m_start = '0; m_per = '0; m_len = 0; m_left = 0;
        end else begin
            bit due_now;
            due_now = (st >= m_next);
            if (!cfg_act_en) begin
                m_run = 0; m_out = 0; m_err = 0;
            end else if (!m_prev_act || (cfg_auto_act && m_prev_wr)) begin
                m_out = 0;
                if (m_start < st) begin
                    m_run = 0; m_err = 1;
                end else begin
                    m_run = 1; m_err = 0; m_next = m_start;
                    m_len = int'(cfg_len); m_per = cfg_cycle;
                end
            end else if (m_run) begin
                if (m_out && m_len == 0) begin
                    if (m_per != 0 && due_now) m_next = m_next + m_per;
                    if (sync_ack) begin
                        m_out = 0;
                        if (m_per == 0) m_run = 0;
                    end
                end else if (m_out) begin
                    if (m_per != 0 && due_now) begin
                        m_left = m_len; m_next = m_next + m_per;
                    end else if (m_left == 1) begin
                        m_out = 0;
                        if (m_per == 0) m_run = 0;
                    end else begin
                        m_left--;
                    end
                end else if (due_now) begin
                    m_out = 1; m_left = m_len;
                    if (m_per != 0) m_next = m_next + m_per;
                end
            end
            if (start_wr) begin
                m_start = cfg_start;
            end else if (start_lo_wr) begin
                m_start = {st[63:32], cfg_start[31:0]};
                if (m_start < st) m_start[63:32] = st[63:32] + 32'd1;
            end
            m_prev_wr  = start_wr | start_lo_wr;
            m_prev_act = cfg_act_en;
        end
        st <= st + 64'd10;
    end

    // per-cycle comparison and edge statistics
    bit          prev_s = 0;
    int          rise_cnt = 0, hi_run = 0, last_hi = 0, cyc_since = 0, last_period = 0;
    logic [63:0] rise_st = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(sync0 === m_out, cur_req, "sync0 vs model", 64'(sync0), 64'(m_out));
            chk(start_err === m_err, cur_req, "start_err vs model", 64'(start_err), 64'(m_err));
            cyc_since++;
            if (sync0 && !prev_s) begin
                rise_cnt++;
                rise_st = st - 64'd10;
                last_period = cyc_since;
                cyc_since = 0;
                hi_run = 0;
            end
            if (sync0) hi_run++;
            if (!sync0 && prev_s) last_hi = hi_run;
            prev_s = sync0;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 60000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 60000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic arm_full(input logic [63:0] s, input logic [15:0] len,
                            input logic [31:0] cyc);
        cfg_act_en = 0;
        step();
        cfg_start = s; start_wr = 1;
        step();
        start_wr = 0; cfg_len = len; cfg_cycle = cyc; cfg_act_en = 1;
        rise_cnt = 0; last_hi = 0;
        step();
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 400 && sync0 !== 1'b1; i++) step();
    endtask

    logic [63:0] exp_s;

    initial begin
        step(4);
        cur_req = "R1";
        chk(sync0 === 1'b0, "R1", "sync0 after reset", 64'(sync0), 0);
        chk(start_err === 1'b0, "R1", "start_err after reset", 64'(start_err), 0);
        rst_n = 1;
        step();

        // R7: low-half write crossing a low-half rollover
        cur_req = "R7";
        cfg_start = 64'h40; start_lo_wr = 1;
        exp_s = {st[63:32], 32'h40};
        if (exp_s < st) exp_s[63:32] = st[63:32] + 32'd1;
        step();
        start_lo_wr = 0; cfg_len = 2; cfg_cycle = 0; cfg_act_en = 1; rise_cnt = 0;
        step();
        wait_rise();
        chk(exp_s[63:32] == 32'd2, "R7", "extended upper half", exp_s[63:32], 2);
        chk(rise_st >= exp_s && rise_st < exp_s + 10, "R7", "rise time carry", rise_st, exp_s);
        cfg_act_en = 0;
        step();
        cfg_start = {32'h0, st[31:0] + 32'd150}; start_lo_wr = 1;
        exp_s = {st[63:32], st[31:0] + 32'd150};
        step();
        start_lo_wr = 0; cfg_act_en = 1; rise_cnt = 0;
        step();
        wait_rise();
        chk(rise_st >= exp_s && rise_st < exp_s + 10, "R7", "rise time no carry", rise_st, exp_s);
        step(5);

        // R2: cyclic fixed width
        cur_req = "R2";
        arm_full(st + 200, 3, 100);
        step(70);
        chk(last_hi == 3, "R2", "pulse width", 64'(last_hi), 3);
        chk(last_period == 10, "R2", "pulse spacing", 64'(last_period), 10);
        chk(rise_cnt >= 4, "R2", "pulse count", 64'(rise_cnt), 4);

        // R12: config changes after arming are ignored
        cur_req = "R12";
        arm_full(st + 100, 2, 100);
        wait_rise();
        cfg_len = 7; cfg_cycle = 30;
        step(40);
        chk(last_hi == 2, "R12", "width kept", 64'(last_hi), 2);
        chk(last_period == 10, "R12", "spacing kept", 64'(last_period), 10);

        // R3: single shot
        cur_req = "R3";
        arm_full(st + 100, 4, 0);
        step(40);
        chk(rise_cnt == 1, "R3", "one pulse", 64'(rise_cnt), 1);
        chk(last_hi == 4, "R3", "single width", 64'(last_hi), 4);

        // R8: auto-activation by start write
        cur_req = "R8";
        cfg_auto_act = 1; rise_cnt = 0;
        cfg_start = st + 100; start_wr = 1;
        step();
        start_wr = 0;
        step(30);
        chk(rise_cnt == 1, "R8", "auto armed pulse", 64'(rise_cnt), 1);
        cfg_auto_act = 0;

        // R11: period shorter than width keeps output high
        cur_req = "R11";
        arm_full(st + 50, 20, 50);
        step(60);
        chk(sync0 === 1'b1, "R11", "retriggered high", 64'(sync0), 1);
        chk(rise_cnt == 1, "R11", "single rise", 64'(rise_cnt), 1);

        // R10: deactivation forces low
        cur_req = "R10";
        cfg_act_en = 0;
        step();
        chk(sync0 === 1'b0, "R10", "low after deactivate", 64'(sync0), 0);
        step(3);

        // R4: cyclic acknowledge
        cur_req = "R4";
        arm_full(st + 50, 0, 80);
        wait_rise();
        step(12);
        chk(sync0 === 1'b1, "R4", "held across due times", 64'(sync0), 1);
        sync_ack = 1;
        step();
        sync_ack = 0;
        chk(sync0 === 1'b0, "R4", "cleared by ack", 64'(sync0), 0);
        step(20);
        chk(rise_cnt == 2, "R4", "fires again", 64'(rise_cnt), 2);

        // R5: single shot acknowledge
        cur_req = "R5";
        arm_full(st + 50, 0, 0);
        wait_rise();
        step(15);
        chk(sync0 === 1'b1, "R5", "held until ack", 64'(sync0), 1);
        sync_ack = 1;
        step();
        sync_ack = 0;
        step(30);
        chk(sync0 === 1'b0 && rise_cnt == 1, "R5", "idle after ack", 64'(rise_cnt), 1);

        // R6: first rise at start time
        cur_req = "R6";
        exp_s = st + 300;
        arm_full(exp_s, 2, 0);
        step(40);
        chk(rise_st >= exp_s && rise_st < exp_s + 10, "R6", "first rise time", rise_st, exp_s);

        // R9: start in the past
        cur_req = "R9";
        arm_full(st - 100, 2, 50);
        chk(start_err === 1'b1, "R9", "error flagged", 64'(start_err), 1);
        step(20);
        chk(rise_cnt == 0 && sync0 === 1'b0, "R9", "no pulse", 64'(rise_cnt), 0);
        cfg_act_en = 0;
        step(2);
        chk(start_err === 1'b0, "R9", "error cleared", 64'(start_err), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule